// File: doc/BRIEF.md
# Cascadable Serial Switch-Enable Register

This block is the low-voltage control core for a bank of independent high-voltage switches. A serial bit stream is shifted into a register one bit per qualified clock edge. A level-controlled latch stage decides which register contents reach the per-channel switch-enable outputs. A clear input forces every enable off at once. The last register stage is brought out on a serial output, so several blocks can be chained into one long control word.

The block runs on a system clock. A `shift_en` strobe marks the cycles in which one bit moves in, so `shift_en` plays the role of the serial shift clock. The serial input has no back-pressure and no ready signal. A bit offered with `shift_en` high is always taken on that edge, and `dout` of one block can be wired straight to `din` of the next. The recommended load procedure has three steps. Hold `hold_le` high while all bits are shifted. Pull it low for one cycle to publish the new word. Raise it again.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, every shift stage and the latch are zero, so `sw_en` is all zeros and `dout` is 0.
- R2: At a rising `clk` with `shift_en` high, `din` enters stage 0 and every stage k moves to stage k+1. With `shift_en` low, no stage changes and `dout` holds.
- R3: `dout` equals stage WIDTH-1. After WIDTH shifts, the first bit sent appears on `dout`.
- R4: While `hold_le` is low and `clr` is low, `sw_en` equals the shift stages. It changes in the same cycle the stages change.
- R5: While `hold_le` is high and `clr` is low, `sw_en` keeps the stage contents present at the last edge where `hold_le` was low. Shifting does not change it.
- R6: While `clr` is high, `sw_en` is all zeros, whatever the values of `din`, `shift_en` and `hold_le`. The effect is immediate and needs no clock edge.
- R7: `clr` alters neither the shift stages nor the latched word. When `clr` falls, `sw_en` shows again what R4 or R5 gives, and `dout` is never affected by `clr`.
- R8: Bit k of `sw_en` drives channel k. A 1 turns that switch on and a 0 turns it off.
- R9: Two blocks with the upstream `dout` wired to the downstream `din`, and sharing `shift_en` and `hold_le`, act as one 2*WIDTH register. The first bit sent ends in downstream channel WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; stages update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data bit, taken when shift_en is high |
| shift_en | input | 1 | Shift strobe; each high cycle moves one bit in |
| hold_le | input | 1 | Low: latch follows the stages; high: latch holds |
| clr | input | 1 | Forces all switch enables off, overrides all else |
| sw_en | output | WIDTH | Per-channel switch enable, 1 = on |
| dout | output | 1 | Last shift stage, for cascading |

## Verification
The bench shifts a full word with `hold_le` high and checks that the outputs do not move. A latch that leaks would show partial words while the bits are in flight. It then opens a transparent window and checks that `sw_en` follows every single shift. A latch that only loads on an edge would lag here. In the middle of a sequence it raises `clr` while shifting continues, then checks the word after `clr` falls. A clear that wiped the register, or that was applied one clock late, would show a wrong word or one cycle of stale enables. A 32-bit load through two chained blocks checks the bit order and the stage that feeds `dout`. An off-by-one in either would put the word into the wrong channels.

// File: rtl/serial_switch_ctrl_pkg.sv
package serial_switch_ctrl_pkg;
  localparam int unsigned DEF_WIDTH = 16;

  typedef enum logic {
    LATCH_FOLLOW = 1'b0,
    LATCH_HOLD   = 1'b1
  } latch_mode_e;
endpackage

// File: rtl/swctl_shift_chain.sv
module swctl_shift_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             shift_en,
  output logic [WIDTH-1:0] stage_q,
  output logic [WIDTH-1:0] stage_nxt,
  output logic             tail
);
  localparam int unsigned LAST = WIDTH - 1;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic feed;
    if (k == 0) begin : g_head
      assign feed = din;
    end else begin : g_body
      assign feed = stage_q[k-1];
    end

    assign stage_nxt[k] = shift_en ? feed : stage_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= 1'b0;
      else        stage_q[k] <= stage_nxt[k];
    end
  end

  assign tail = stage_q[LAST];
endmodule

// File: rtl/swctl_latch.sv
module swctl_latch
  import serial_switch_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_le,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] live_val,
  output logic [WIDTH-1:0] view
);
  latch_mode_e      mode;
  logic [WIDTH-1:0] hold_q;

  assign mode = hold_le ? LATCH_HOLD : LATCH_FOLLOW;

  // Explicit-enable model of a level latch: it tracks while following
  // and stops updating once the enable is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hold_q <= '0;
    else if (mode == LATCH_FOLLOW) hold_q <= load_val;
  end

  always_comb begin
    unique case (mode)
      LATCH_FOLLOW: view = live_val;
      LATCH_HOLD:   view = hold_q;
      default:      view = hold_q;
    endcase
  end
endmodule

// File: rtl/swctl_clear_gate.sv
module swctl_clear_gate #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clr,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out
);
  for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
    assign word_out[ch] = word_in[ch] & ~clr;
  end
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl
  import serial_switch_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             shift_en,
  input  logic             hold_le,
  input  logic             clr,
  output logic [WIDTH-1:0] sw_en,
  output logic             dout
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;
  logic [WIDTH-1:0] latch_view;

  swctl_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .shift_en  (shift_en),
    .stage_q   (stage_q),
    .stage_nxt (stage_nxt),
    .tail      (dout)
  );

  swctl_latch #(.WIDTH(WIDTH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_le  (hold_le),
    .load_val (stage_nxt),
    .live_val (stage_q),
    .view     (latch_view)
  );

  swctl_clear_gate #(.WIDTH(WIDTH)) u_gate (
    .clr      (clr),
    .word_in  (latch_view),
    .word_out (sw_en)
  );
endmodule

// File: rtl/serial_switch_ctrl_chk.sv
module serial_switch_ctrl_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din,
  input logic             shift_en,
  input logic             hold_le,
  input logic             clr,
  input logic [WIDTH-1:0] sw_en,
  input logic             dout
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (sw_en == '0 && !dout));

  p_idle_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dout));

  p_tail_feeds_dout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !hold_le && !clr) |=> dout == $past(sw_en[WIDTH-2]));

  p_follow_din_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !hold_le && !clr) |=> (hold_le || clr || sw_en[0] == $past(din)));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_le && $past(hold_le) && !clr && !$past(clr)) |-> $stable(sw_en));

  p_clear_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> sw_en == '0);
endmodule

bind serial_switch_ctrl serial_switch_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .din      (din),
  .shift_en (shift_en),
  .hold_le  (hold_le),
  .clr      (clr),
  .sw_en    (sw_en),
  .dout     (dout)
);

// File: tb/serial_switch_ctrl_bench.sv
module serial_switch_ctrl_bench;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] sw_a;
    logic [W-1:0] sw_b;
    logic         do_a;
    logic         do_b;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, shift_en = 1'b0, hold_le = 1'b1, clr = 1'b0;
  logic [W-1:0] sw_a, sw_b;
  logic do_a, do_b;

  int checks = 0;
  int failures = 0;
  exp_t sb_q[$];

  logic [2*W-1:0] m_chain = '0;
  logic [2*W-1:0] m_hold  = '0;

  always #10 clk = ~clk;

  serial_switch_ctrl #(.WIDTH(W)) u_serial_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .din(din), .shift_en(shift_en),
    .hold_le(hold_le), .clr(clr), .sw_en(sw_a), .dout(do_a));

  serial_switch_ctrl #(.WIDTH(W)) u_serial_switch_ctrl_b (
    .clk(clk), .rst_n(rst_n), .din(do_a), .shift_en(shift_en),
    .hold_le(hold_le), .clr(clr), .sw_en(sw_b), .dout(do_b));

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the model's expectation.
  task automatic step(input logic d, input logic sh, input logic l, input logic c, input string req);
    exp_t e;
    logic [2*W-1:0] view;
    @(negedge clk);
    din = d; shift_en = sh; hold_le = l; clr = c;
    @(posedge clk);
    if (sh) m_chain = {m_chain[2*W-2:0], d};
    if (!l) m_hold = m_chain;
    view = l ? m_hold : m_chain;
    if (c) view = '0;
    e.sw_a = view[W-1:0];
    e.sw_b = view[2*W-1:W];
    e.do_a = m_chain[W-1];
    e.do_b = m_chain[2*W-1];
    e.req  = req;
    sb_q.push_back(e);
  endtask

  task automatic shift_word(input logic [W-1:0] word, input logic l, input string req);
    for (int i = W - 1; i >= 0; i--) step(word[i], 1'b1, l, 1'b0, req);
  endtask

  // Monitor: compares after outputs settle, away from the clock edge.
  always @(posedge clk) begin
    #5;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(sw_a == e.sw_a && sw_b == e.sw_b && do_a == e.do_a && do_b == e.do_b, e.req,
            $sformatf("%h/%h/%b%b", sw_a, sw_b, do_a, do_b),
            $sformatf("%h/%h/%b%b", e.sw_a, e.sw_b, e.do_a, e.do_b));
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, with hold_le low so the stages are also visible
    hold_le = 1'b0; din = 1'b1; shift_en = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check(sw_a == '0 && !do_a && sw_b == '0, "R1",
          $sformatf("%h %b", sw_a, do_a), "0000 0");
    @(negedge clk);
    shift_en = 1'b0; din = 1'b0; hold_le = 1'b1;
    rst_n = 1'b1;

    // R5: shift a full word while held; outputs stay at zero
    shift_word(16'hA5C3, 1'b1, "R5 hold while shifting");
    // R4/R8: open for one cycle to publish; channel k follows bit k
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4 publish");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5 capture");
    #15 check(sw_a == 16'hA5C3, "R8", $sformatf("%h", sw_a), "a5c3");

    // R5/R3: new word shifted while held; dout carries old word out
    shift_word(16'h0001, 1'b1, "R3 dout while held");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4 publish single");
    #15 check(sw_a == 16'h0001, "R8 channel 0 only", $sformatf("%h", sw_a), "0001");

    // R2: idle cycles change nothing
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 idle");

    // R4: transparent window, outputs follow every shift
    shift_word(16'h6E19, 1'b0, "R4 transparent");

    // R6/R7: clear mid-sequence while shifting continues
    for (int i = 0; i < 5; i++) step(i[0], 1'b1, 1'b0, 1'b1, "R6 clear while shifting");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 release after clear");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7 capture after clear");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R6 clear while held");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7 held word returns");

    // R9: 32-bit cascaded load, then publish
    shift_word(16'hF00D, 1'b1, "R9 cascade upper half");
    shift_word(16'h1357, 1'b1, "R9 cascade lower half");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R9 publish");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9 capture");
    #15 check(sw_b == 16'hF00D && sw_a == 16'h1357, "R9",
              $sformatf("%h%h", sw_b, sw_a), "f00d1357");

    repeat (2) @(posedge clk);
    #8;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule